// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division one bit per clock and keeps the outcome in two dedicated result registers, HI and LO. A core launches an operation with a single-cycle `start` pulse, a two-bit operation code and two operands. The unit then runs without further input and raises `done` for one cycle when the result pair has been written.

A multiply places the full double-width product across the pair: the upper word goes to HI and the lower word to LO. A divide places the quotient in LO and the remainder in HI. The core never writes HI or LO. It reads them through the two read ports, `hi` and `lo`, which serve its move-from-HI and move-from-LO instructions. While `busy` is high the core stalls those moves. Signed forms work on operand magnitudes and correct the signs at the end. The quotient truncates toward zero, and the remainder carries the sign of the dividend.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, `busy` and `done` are low and `hi` and `lo` are both zero.
- R2: Operation code 2'b00 (unsigned multiply) writes the upper 32 bits of the unsigned 64-bit product to `hi` and the lower 32 bits to `lo`.
- R3: Operation code 2'b01 (signed multiply) treats both operands as two's complement and writes the 64-bit signed product split the same way as R2.
- R4: Operation code 2'b10 (unsigned divide) with a nonzero divisor writes the quotient to `lo` and the remainder to `hi`.
- R5: Operation code 2'b11 (signed divide) with a nonzero divisor writes a quotient truncated toward zero to `lo` and a remainder with the dividend's sign to `hi`. The case 0x80000000 / -1 gives quotient 0x80000000 and remainder 0.
- R6: A divide, signed or unsigned, whose divisor is zero completes with normal timing and leaves `lo` = 0xFFFFFFFF and `hi` = the dividend as given.
- R7: `busy` is high on the cycle after the clock edge that accepts `start`. `done` rises exactly 33 cycles after that edge, stays high for one cycle only, and is never high together with `busy`.
- R8: A `start` that arrives while `busy` is high is ignored. It changes neither the running operation's result nor its completion time, and it does not start an operation afterwards.
- R9: `hi` and `lo` change only on the cycle in which `done` is high. At all other times they hold their values, including while an operation is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse, taken only when idle |
| op | input | 2 | Bit 1: divide (1) or multiply (0); bit 0: signed (1) or unsigned (0) |
| opa | input | W (32) | Multiplicand, or dividend |
| opb | input | W (32) | Multiplier, or divisor |
| busy | output | 1 | Operation in progress; the core stalls move-from reads |
| done | output | 1 | One-cycle pulse when HI/LO have been written |
| hi | output | W (32) | HI register read port |
| lo | output | W (32) | LO register read port |

## Verification
The hardest situation to reach is a second `start` that lands in the middle of a running operation, carrying different operands and a different operation code. The effect of ignoring it shows up only when the first operation finishes. A dedicated scenario fires that pulse five cycles into a multiply and then checks three things: HI/LO still hold the previous result one cycle before completion, the final pair is the multiply's product and not the quotient, and `busy` stays low after `done`. The sign-correction corners are driven directly with chosen operands: the most negative value, divide by zero, and mixed operand signs.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int CW = $clog2(W);
  localparam logic [1:0] S_IDLE = 2'd0, S_RUN = 2'd1, S_FIX = 2'd2;

  logic [1:0]     st;
  logic [CW-1:0]  cnt;
  logic [W-1:0]   acc_hi, acc_lo, m, dvd;
  logic           is_div, neg_q, neg_r, dz;

  logic           a_neg, b_neg;
  logic [W-1:0]   a_mag, b_mag;
  assign a_neg = op[0] & opa[W-1];
  assign b_neg = op[0] & opb[W-1];
  assign a_mag = a_neg ? -opa : opa;
  assign b_mag = b_neg ? -opb : opb;

  // one shift-and-add or restoring-subtract step
  logic [W:0]     msum, shf;
  logic [W-1:0]   sub;
  logic           ge;
  logic [W-1:0]   nxt_hi, nxt_lo;
  assign msum   = {1'b0, acc_hi} + {1'b0, (acc_lo[0] ? m : {W{1'b0}})};
  assign shf    = {acc_hi, acc_lo[W-1]};
  assign ge     = shf >= {1'b0, m};
  assign sub    = shf[W-1:0] - m;
  assign nxt_hi = is_div ? (ge ? sub : shf[W-1:0]) : msum[W:1];
  assign nxt_lo = is_div ? {acc_lo[W-2:0], ge} : {msum[0], acc_lo[W-1:1]};

  // sign correction
  logic [2*W-1:0] prod, prod_f;
  logic [W-1:0]   quo_f, rem_f, res_hi, res_lo;
  assign prod   = {acc_hi, acc_lo};
  assign prod_f = neg_q ? -prod : prod;
  assign quo_f  = neg_q ? -acc_lo : acc_lo;
  assign rem_f  = neg_r ? -acc_hi : acc_hi;
  assign res_hi = is_div ? (dz ? dvd : rem_f) : prod_f[2*W-1:W];
  assign res_lo = is_div ? (dz ? {W{1'b1}} : quo_f) : prod_f[W-1:0];

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      acc_hi <= '0;
      acc_lo <= '0;
      m      <= '0;
      dvd    <= '0;
      is_div <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      dz     <= 1'b0;
      done   <= 1'b0;
      hi     <= '0;
      lo     <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st     <= S_RUN;
          cnt    <= '0;
          is_div <= op[1];
          neg_q  <= a_neg ^ b_neg;
          neg_r  <= a_neg;
          dz     <= op[1] & (opb == '0);
          dvd    <= opa;
          acc_hi <= '0;
          acc_lo <= op[1] ? a_mag : b_mag;
          m      <= op[1] ? b_mag : a_mag;
        end
        S_RUN: begin
          acc_hi <= nxt_hi;
          acc_lo <= nxt_lo;
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) st <= S_FIX;
        end
        S_FIX: begin
          st   <= S_IDLE;
          done <= 1'b1;
          hi   <= res_hi;
          lo   <= res_lo;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_hilo_sva.sv
module muldiv_hilo_sva #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo
);
  logic [31:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= busy ? lat_q + 32'd1 : 32'd0;
  end

  assert_busy_after_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_q == 32'(W + 1));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> busy || done);
  assert_hilo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(hi) && $stable(lo));
endmodule

bind muldiv_hilo muldiv_hilo_sva #(.W(W)) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .hi(hi), .lo(lo)
);

// File: tb/tb_muldiv_hilo.sv
module tb_muldiv_hilo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0, opb = '0;
  logic        busy, done;
  logic [31:0] hi, lo;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  muldiv_hilo #(.W(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, q, r;
    logic [63:0] qv, rv;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      2'b00: return {32'b0, a} * {32'b0, b};
      2'b01: return 64'(sa * sb);
      2'b10: return (b == 0) ? {a, 32'hFFFF_FFFF} : {a % b, a / b};
      default: begin
        if (b == 0) return {a, 32'hFFFF_FFFF};
        q = sa / sb; r = sa % sb;
        qv = 64'(q); rv = 64'(r);
        return {rv[31:0], qv[31:0]};
      end
    endcase
  endfunction

  function automatic string tag(input logic [1:0] o, input logic [31:0] b);
    if (o[1] && b == 0) return "R6";
    case (o)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 hi", hi, 0);
    check("R1 lo", lo, 0);
  endtask

  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] exp;
    string rq;
    exp = model(o, a, b);
    rq = tag(o, b);
    @(negedge clk); op = o; opa = a; opb = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R7 busy after start", busy, 1);
    for (int k = 1; k <= 33; k++) begin
      @(negedge clk);
      if (k == 32) check("R7 done low before latency", {busy, done}, 2'b10);
    end
    check("R7 done at latency", {busy, done}, 2'b01);
    check({rq, " hi:lo result"}, {hi, lo}, exp);
    @(negedge clk);
    check("R7 done one cycle", done, 0);
    repeat (3) @(negedge clk);
    check("R9 hi:lo held after done", {hi, lo}, exp);
  endtask

  task automatic t_ignore;
    logic [63:0] prev;
    run_op(2'b10, 32'd1000, 32'd7);
    prev = {hi, lo};
    @(negedge clk); op = 2'b00; opa = 32'd3; opb = 32'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 1; k <= 34; k++) begin
      if (k == 5) begin op = 2'b11; opa = 32'd100; opb = 32'hFFFF_FFF9; start = 1'b1; end
      if (k == 6) start = 1'b0;
      @(negedge clk);
      if (k == 32) check("R9 hi:lo held while busy", {hi, lo}, prev);
      if (k == 33) begin
        check("R8 done timing unchanged", {busy, done}, 2'b01);
        check("R8 result of first op", {hi, lo}, 64'd15);
      end
      if (k == 34) check("R8 no deferred start", busy, 0);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    // R2
    run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(2'b00, 32'd12345, 32'd6789);
    // R3
    run_op(2'b01, 32'hFFFF_FFFD, 32'd7);
    run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(2'b01, 32'h8000_0000, 32'h8000_0000);
    // R4
    run_op(2'b10, 32'd100, 32'd7);
    run_op(2'b10, 32'hFFFF_FFFF, 32'd3);
    run_op(2'b10, 32'd5, 32'd9);
    // R5
    run_op(2'b11, 32'hFFFF_FFF9, 32'd2);
    run_op(2'b11, 32'd7, 32'hFFFF_FFFE);
    run_op(2'b11, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
    run_op(2'b11, 32'h8000_0000, 32'hFFFF_FFFF);
    // R6
    run_op(2'b10, 32'd77, 32'd0);
    run_op(2'b11, 32'hFFFF_FFFB, 32'd0);
    // R8, R9
    t_ignore();
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (i % 6 == 5) ? 32'(($urandom % 9) + 1) : $urandom;
      run_op(2'(i % 4), a, b);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule